// File: doc/BRIEF.md
# Burst Synchronous Serial Port

This block is an 8-bit clocked serial channel with an 8-entry byte buffer. Software loads up to eight outgoing bytes through a write stream, programs a byte count from 1 to 8 and pulses a start input. The port then moves that many bytes over the serial pins by itself and raises a completion flag. Each received byte replaces, in arrival order, the outgoing byte it was exchanged for. The received bytes are then drained through a read stream.

The same buffer serves both directions. At the first clock edge of a byte, that byte leaves the head of the buffer. When its eighth bit has been sampled, the byte received in its place enters at the tail. As master the port makes the serial clock itself: idle high, 16 system clocks per bit, 8 low and 8 high. As slave it follows an external clock through a two-stage synchronizer. In select-gated mode an active-low select input must be low before any bit moves. While select is high, clock and data outputs are released. If select rises part way through a byte, the transfer is aborted.

The write stream moves a byte when `wr_valid && wr_ready`. The read stream moves a byte when `rd_valid && rd_ready`. Both streams are held off (`wr_ready` and `rd_valid` low) for the whole of a transfer. Outside a transfer, back-pressure comes only from the buffer being full (write) or empty (read). Data offered while ready is low is not taken and must be held.

Top module: `burst_serial_port`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0, `level` is 0, `wr_ready` is 1, `rd_valid` is 0 and `sck_out` is 1.
- R2: `wr_ready` is 1 exactly when no transfer is running and `level` is below 8. `rd_valid` is 1 exactly when no transfer is running and `level` is above 0. Bytes are read back in the order they were written, and a write offered while full is not taken.
- R3: `xfer_start` is accepted only when idle and when `xfer_len` is between 1 and 8 and not above `level`. Otherwise it is ignored: `busy` stays 0 and `level` is unchanged.
- R4: As master with select gating off, `sck_out` idles at 1. Its first falling edge follows in the clock cycle after the start is accepted, and each phase lasts 8 system clocks (16-clock bit period).
- R5: Bits go most significant first. `so_out` takes a new bit at each falling serial clock edge, and `si_in` is sampled at each rising edge.
- R6: Each byte is removed from the buffer head at its first falling edge. The byte received for it is appended at the tail after its eighth rising edge, so an N-byte transfer from N loaded bytes leaves the N received bytes in arrival order.
- R7: `busy` falls and `done` rises at the same clock edge. As master, that edge comes 128·N − 7 clocks after the edge that accepted the start. An accepted start clears `done` and `err`.
- R8: As slave (`cfg_master` = 0), bits are clocked by `sck_in` after a two-flop synchronizer, and `sck_oe` is 0.
- R9: With select gating on (`cfg_cs_mode` = 1), no serial clock runs and no bit moves while `cs_n_in` is high. `sck_oe` and `so_oe` are 0 two clocks after `cs_n_in` goes high, and they follow the synchronized select when it goes low.
- R10: In select-gated mode, a rise of select while a byte is part way through ends the transfer. `busy` goes to 0 and `err` to 1, and `done` stays 0. The partial received byte is dropped and the byte being sent is lost, so `level` ends one below its value at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: drive serial clock; 0: follow `sck_in` |
| cfg_cs_mode | input | 1 | 1: gate shifting with `cs_n_in` |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | 8 | Byte to load |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| rd_data | output | 8 | Byte at buffer head |
| xfer_len | input | 4 | Byte count for the next transfer, 1 to 8 |
| xfer_start | input | 1 | Start pulse |
| busy | output | 1 | Transfer running |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky abort flag |
| level | output | 4 | Bytes held in the buffer |
| sck_in | input | 1 | Serial clock in (slave) |
| sck_out | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| si_in | input | 1 | Serial data in |
| so_out | output | 1 | Serial data out |
| so_oe | output | 1 | Serial data output enable |
| cs_n_in | input | 1 | Active-low select |

## Verification
Everything in master mode is timed from the edge that takes the start pulse, with E0 being that edge. The first falling serial edge comes at E1 and the first rising edge at E9. Later edges follow every 8 clocks, and `done` rises at E(128·N−7). The bench walks the transfer one clock at a time and compares at the falling system clock edge just after each of these edges. Slave-mode and select effects pass through two synchronizer flops plus one register stage, so the bench holds each serial phase for six clocks and samples only after that margin.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BUF_DEPTH = 8;
  localparam int unsigned HALF_CLKS = 8;
  localparam int unsigned SYNC_LEN  = 2;
  localparam int unsigned LVL_W     = $clog2(BUF_DEPTH + 1);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bsp_sync.sv
module bsp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bsp_fifo.sv
module bsp_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [CW-1:0] count,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  assign head  = mem[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/bsp_clkgen.sv
module bsp_clkgen #(
  parameter int unsigned HALF = 8,
  localparam int unsigned CW  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall,
  output logic rise
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(HALF - 1));
  assign fall = tick && sck;
  assign rise = tick && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(HALF - 1);
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= CW'(HALF - 1);
      sck <= 1'b1;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bsp_engine.sv
module bsp_engine #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned BW   = $clog2(W),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic [CW-1:0] len,
  input  logic          fall,
  input  logic          rise,
  input  logic          si,
  input  logic          abort_req,
  input  logic [W-1:0]  head,
  output logic          pop,
  output logic          push,
  output logic [W-1:0]  push_data,
  output logic          so,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mid_byte
);
  logic [W-1:0]  tx_sh, rx_sh;
  logic [BW-1:0] bit_idx;
  logic [CW-1:0] left;
  logic          abort, last_bit;

  assign abort     = busy && abort_req && mid_byte;
  assign last_bit  = (bit_idx == BW'(W - 1));
  assign pop       = busy && !abort && fall && !mid_byte;
  assign push      = busy && !abort && rise && mid_byte && last_bit;
  assign push_data = {rx_sh[W-2:0], si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      mid_byte <= 1'b0;
      bit_idx  <= '0;
      left     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      so       <= 1'b1;
    end else if (start_ok) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      mid_byte <= 1'b0;
      bit_idx  <= '0;
      left     <= len;
    end else if (busy) begin
      if (abort) begin
        busy     <= 1'b0;
        err      <= 1'b1;
        mid_byte <= 1'b0;
        bit_idx  <= '0;
      end else begin
        if (fall) begin
          if (!mid_byte) begin
            so       <= head[W-1];
            tx_sh    <= head << 1;
            mid_byte <= 1'b1;
          end else begin
            so    <= tx_sh[W-1];
            tx_sh <= tx_sh << 1;
          end
        end
        if (rise && mid_byte) begin
          rx_sh <= push_data;
          if (last_bit) begin
            bit_idx  <= '0;
            mid_byte <= 1'b0;
            left     <= left - 1'b1;
            if (left == CW'(1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));
  assert_err_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(busy) && !busy && !done));
endmodule

// File: rtl/burst_serial_port.sv
module burst_serial_port
  import bsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_cs_mode,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [LVL_W-1:0] xfer_len,
  input  logic             xfer_start,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [LVL_W-1:0] level,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             si_in,
  output logic             so_out,
  output logic             so_oe,
  input  logic             cs_n_in
);
  logic sck_s, si_s, cs_s, sck_d, cs_d;
  logic s_fall, s_rise, g_fall, g_rise, e_fall, e_rise;
  logic cs_ok, run, start_ok, cs_rise;
  logic full, empty, ext_push, ext_pop, eng_push, eng_pop, mid_byte;
  byte_t head, eng_data, fifo_in;

  bsp_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_s));
  bsp_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync_si (
    .clk(clk), .rst_n(rst_n), .d(si_in), .q(si_s));
  bsp_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n_in), .q(cs_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b1;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign s_fall  = sck_d && !sck_s;
  assign s_rise  = !sck_d && sck_s;
  assign cs_rise = cs_s && !cs_d;
  assign cs_ok   = !cfg_cs_mode || !cs_s;
  assign run     = busy && cs_ok && cfg_master;

  bsp_clkgen #(.HALF(HALF_CLKS)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sck(sck_out), .fall(g_fall), .rise(g_rise));

  assign e_fall = cs_ok && (cfg_master ? g_fall : s_fall);
  assign e_rise = cs_ok && (cfg_master ? g_rise : s_rise);

  assign start_ok = xfer_start && !busy && (xfer_len != '0) &&
                    (xfer_len <= LVL_W'(BUF_DEPTH)) && (xfer_len <= level);

  bsp_engine #(.W(BYTE_W), .DEPTH(BUF_DEPTH)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .len(xfer_len),
    .fall(e_fall), .rise(e_rise), .si(si_s),
    .abort_req(cfg_cs_mode && cs_rise), .head(head),
    .pop(eng_pop), .push(eng_push), .push_data(eng_data),
    .so(so_out), .busy(busy), .done(done), .err(err), .mid_byte(mid_byte));

  assign wr_ready = !busy && !full;
  assign rd_valid = !busy && !empty;
  assign ext_push = wr_valid && wr_ready;
  assign ext_pop  = rd_valid && rd_ready;
  assign fifo_in  = busy ? eng_data : wr_data;
  assign rd_data  = head;

  bsp_fifo #(.W(BYTE_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(ext_push || eng_push), .push_data(fifo_in),
    .pop(ext_pop || eng_pop), .head(head),
    .count(level), .full(full), .empty(empty));

  assign sck_oe = cfg_master && cs_ok;
  assign so_oe  = cs_ok;

  assert_master_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !busy) |=> (sck_out || busy));
  assert_slave_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> !sck_oe);
  assert_cs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_cs_mode && cs_s && !xfer_start && !wr_valid && !rd_ready) |=> $stable(level));
endmodule

// File: tb/burst_serial_port_bench.sv
module burst_serial_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cs_mode = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, xfer_start = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] xfer_len = '0;
  logic s_sck = 1'b1, s_si = 1'b0, m_si = 1'b0, cs_n = 1'b1;
  logic wr_ready, rd_valid, busy, done, err, sck_out, sck_oe, so_out, so_oe, si_in;
  logic [7:0] rd_data;
  logic [3:0] level;

  int checks = 0, errors = 0;
  logic model_en = 1'b0;
  int mb = 0;
  logic [7:0] m_tx [8];
  logic [7:0] m_rx [8];
  logic [7:0] b_tx [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign si_in = cfg_master ? m_si : s_si;

  burst_serial_port u_burst_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cs_mode(cfg_cs_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .xfer_len(xfer_len), .xfer_start(xfer_start),
    .busy(busy), .done(done), .err(err), .level(level),
    .sck_in(s_sck), .sck_out(sck_out), .sck_oe(sck_oe),
    .si_in(si_in), .so_out(so_out), .so_oe(so_oe), .cs_n_in(cs_n));

  always @(negedge sck_out) if (model_en) m_si = m_tx[mb/8][7-(mb%8)];
  always @(posedge sck_out) if (model_en) begin
    m_rx[mb/8][7-(mb%8)] = so_out;
    mb++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_b(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(posedge clk); @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic pop_b(output logic [7:0] b);
    @(negedge clk); b = rd_data; rd_ready = 1'b1;
    @(posedge clk); @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic kick(input int n);
    @(negedge clk); xfer_start = 1'b1; xfer_len = 4'(n);
    @(posedge clk); @(negedge clk); xfer_start = 1'b0;
  endtask

  function automatic logic [7:0] expect_rx(input int i);
    return m_tx[i];
  endfunction

  task automatic master_run(input int n);
    logic [7:0] got;
    int last;
    cfg_master = 1'b1; cfg_cs_mode = 1'b0;
    for (int i = 0; i < n; i++) push_b(b_tx[i]);
    mb = 0; model_en = 1'b1;
    kick(n);
    last = 128*n - 7;
    for (int c = 1; c <= last; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 1) begin
        chk(sck_out == 1'b0, "R4 first fall", sck_out, 0);
        chk(so_out == b_tx[0][7], "R5 msb first", so_out, b_tx[0][7]);
      end
      if (c == 8)  chk(sck_out == 1'b0, "R4 low phase", sck_out, 0);
      if (c == 9)  chk(sck_out == 1'b1, "R4 rise at 8", sck_out, 1);
      if (c == 17) chk(sck_out == 1'b0, "R4 period 16", sck_out, 0);
      if (c == 3)  chk(!wr_ready && !rd_valid, "R2 stalled in transfer", wr_ready, 0);
      if (c == last - 1) chk(busy && !done, "R7 not yet done", done, 0);
      if (c == last) chk(done && !busy, "R7 done timing", {busy, done}, 1);
    end
    model_en = 1'b0;
    chk(level == 4'(n), "R6 level kept", level, n);
    for (int i = 0; i < n; i++) begin
      pop_b(got);
      chk(got == expect_rx(i), "R6 rx order", got, expect_rx(i));
      chk(m_rx[i] == b_tx[i], "R5 tx bits", m_rx[i], b_tx[i]);
    end
  endtask

  task automatic slave_byte(input logic [7:0] tx, output logic [7:0] rx, input int bits);
    rx = '0;
    for (int k = 7; k > 7 - bits; k--) begin
      s_sck = 1'b0; s_si = tx[k];
      repeat (6) @(negedge clk);
      rx[k] = so_out;
      s_sck = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] got, rx;
    int seed_v;
    seed_v = $urandom(32'h5EED01);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && level == 0, "R1 status", {busy, done, err}, 0);
    chk(wr_ready && !rd_valid && sck_out, "R1 ports", {wr_ready, rd_valid, sck_out}, 5);

    // R2: fill to 8, blocked ninth write, ordered drain
    for (int i = 0; i < 8; i++) push_b(8'(8'h30 + i));
    chk(level == 8 && !wr_ready, "R2 full", level, 8);
    push_b(8'hEE);
    chk(level == 8, "R2 write while full ignored", level, 8);
    for (int i = 0; i < 8; i++) begin
      pop_b(got);
      chk(got == 8'(8'h30 + i), "R2 order", got, 8'h30 + i);
    end
    chk(level == 0 && !rd_valid, "R2 empty", level, 0);

    // R3: ignored starts
    push_b(8'h11); push_b(8'h22);
    kick(0);  chk(!busy && level == 2, "R3 len zero", busy, 0);
    kick(9);  chk(!busy && level == 2, "R3 len nine", busy, 0);
    kick(3);  chk(!busy && level == 2, "R3 len above level", busy, 0);
    pop_b(got); pop_b(got);

    // directed master
    b_tx[0] = 8'hA5; m_tx[0] = 8'h3C;
    master_run(1);
    for (int i = 0; i < 8; i++) begin b_tx[i] = 8'(8'h81 ^ (i*37)); m_tx[i] = 8'(8'hFF - i*19); end
    master_run(8);

    // random master transfers
    for (int it = 0; it < 5; it++) begin
      int n;
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < 8; i++) begin b_tx[i] = 8'($urandom); m_tx[i] = 8'($urandom); end
      master_run(n);
    end

    // R8: slave mode, 2 bytes
    cfg_master = 1'b0; cfg_cs_mode = 1'b0; s_sck = 1'b1;
    push_b(8'hC3); push_b(8'h5A);
    kick(2);
    @(negedge clk);
    chk(!sck_oe && busy, "R8 slave no clock drive", sck_oe, 0);
    slave_byte(8'h96, rx, 8); chk(rx == 8'hC3, "R8 slave tx byte0", rx, 8'hC3);
    slave_byte(8'h0F, rx, 8); chk(rx == 8'h5A, "R8 slave tx byte1", rx, 8'h5A);
    repeat (5) @(negedge clk);
    chk(done && !busy, "R8 slave done", done, 1);
    pop_b(got); chk(got == 8'h96, "R8 slave rx0", got, 8'h96);
    pop_b(got); chk(got == 8'h0F, "R8 slave rx1", got, 8'h0F);

    // R9: select-gated master holds while select high
    cfg_master = 1'b1; cfg_cs_mode = 1'b1; cs_n = 1'b1;
    b_tx[0] = 8'h6E; m_tx[0] = 8'hB1; push_b(b_tx[0]);
    mb = 0; model_en = 1'b1;
    kick(1);
    repeat (40) @(negedge clk);
    chk(busy && sck_out && !sck_oe && !so_oe, "R9 hold while deselected", {sck_oe, so_oe}, 0);
    chk(level == 1, "R9 nothing moved", level, 1);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sck_oe && so_oe, "R9 enables after select", {sck_oe, so_oe}, 3);
    repeat (140) @(negedge clk);
    chk(done && !busy, "R9 completes after select", done, 1);
    model_en = 1'b0;
    pop_b(got); chk(got == 8'hB1, "R9 rx", got, 8'hB1);
    chk(m_rx[0] == 8'h6E, "R9 tx", m_rx[0], 8'h6E);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sck_oe && !so_oe, "R9 release on deselect", {sck_oe, so_oe}, 0);

    // R10: abort mid-byte in slave select mode
    cfg_master = 1'b0; s_sck = 1'b1;
    push_b(8'h44); push_b(8'h99);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    kick(2);
    slave_byte(8'hFF, rx, 3);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(err && !busy && !done, "R10 abort flags", {busy, done, err}, 1);
    chk(level == 1, "R10 partial dropped", level, 1);
    pop_b(got); chk(got == 8'h99, "R10 untouched byte", got, 8'h99);
    push_b(8'h12);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    kick(1);
    @(negedge clk);
    chk(!err && busy, "R7 start clears err", err, 0);
    slave_byte(8'h21, rx, 8);
    repeat (5) @(negedge clk);
    chk(done && rx == 8'h12, "R7 done after restart", rx, 8'h12);
    pop_b(got); chk(got == 8'h21, "R6 rx after restart", got, 8'h21);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule